// File: doc/BRIEF.md
# Exception Entry Sequencer

This block starts exception handling in a processor core. When a pending exception is presented, it computes the handler address and loads it into `newPc`. The handler address is the privileged-code base register plus an offset chosen by the cause. The block also saves the interrupted PC with the current privileged-mode flag folded into bit 0. It then enters privileged mode.

Software calls carry an 8-bit function number. The block splits their entry points into two halves of 64-byte slots, selected by the top bit of the function number.

On entry from normal mode only, eight architectural general registers are exchanged with an internal shadow bank. The exchange uses one read/write lane per register and completes in a single clock edge. Lane i maps to general register 8+i for i = 0..6, and lane 7 maps to general register 25. The surrounding register file performs the write at the same edge at which it supplies the read data.

A one-cycle `entryDone` pulse follows each accepted entry. The pulse tells the issuing logic to clear its pending exception, and further requests are ignored while it is high. A memory-fault entry also captures the fault address, the fault code and the access kind for the handler. A cause code outside the defined set stops the sequencer and raises a sticky fatal error.

Top module: `trap_entry_unit`

## Requirements
- R1: Cause codes 0..9 give the following offsets, and `newPc` equals `palBase` plus that offset, held from the clock edge after acceptance.
  - 0 (reset): 0x000
  - 1 (machine check): 0x080
  - 2 (interprocessor interrupt): 0x100
  - 3 (clock interrupt): 0x180
  - 4 (device interrupt): 0x200
  - 5 (memory fault): 0x280
  - 6 (unaligned access): 0x300
  - 7 (illegal opcode): 0x380
  - 8 (arithmetic): 0x400
  - 9 (FP disabled): 0x480
- R2: For cause 10 (software call) with `callFunc` bit 7 clear, the offset is 0x1000 + `callFunc`*64.
- R3: For cause 10 with `callFunc` bit 7 set, the offset is 0x2000 + (`callFunc` - 0x80)*64.
- R4: On acceptance, `excAddr` becomes `curPc` OR'd with the privileged-mode flag as it was before entry, in bit 0.
- R5: An entry accepted while `privMode` is 0 has three effects in the acceptance cycle:
  - `swapWrEn` is all ones and every `swapWrData` lane holds the shadow bank.
  - At that edge, the shadow bank takes `swapRdData`.
  - `privMode` becomes 1.
- R6: An entry accepted while `privMode` is 1 leaves `swapWrEn` at zero and the shadow bank unchanged, so `swapWrData` keeps its value. `privMode` stays 1 until reset.
- R7: `entryDone` is high for exactly the one cycle after acceptance. A request present during that cycle is ignored: no outputs change and `swapWrEn` stays zero.
- R8: A request with cause 11..15 sets `fatalErr`, which stays set until reset. It gives no `entryDone` and changes neither `newPc`, `excAddr`, `privMode` nor the shadow bank. After it, all requests are ignored.
- R9: A cause-5 entry latches three trap arguments:
  - `trapArg0` takes `faultAddr`.
  - `trapArg1` takes `faultCode`, zero-extended.
  - `trapArg2` takes all ones when `faultKind` bit 1 is set (instruction fetch). Otherwise it takes `faultKind` bit 0 (0 read, 1 write).

  Any other entry leaves all three trap arguments unchanged.
- R10: After reset, the following are zero: `privMode`, `entryDone`, `fatalErr`, `newPc`, `excAddr`, the trap arguments and the shadow bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | Exception pending |
| excCause | input | 4 | Cause code |
| callFunc | input | 8 | Software-call function number |
| curPc | input | 64 | PC of the interrupted instruction |
| palBase | input | 64 | Privileged-code base register |
| faultAddr | input | 64 | Faulting virtual address |
| faultCode | input | 8 | Memory-fault reason code |
| faultKind | input | 2 | Access kind: 0 read, 1 write, 2 or 3 fetch |
| swapRdData | input | 512 | Current values of the eight swapped registers, lane i at bits 64i+63:64i |
| swapWrData | output | 512 | Values to write into the swapped registers (shadow bank) |
| swapWrEn | output | 8 | Per-lane write enable for the swapped registers |
| newPc | output | 64 | Handler address |
| excAddr | output | 64 | Saved return address with mode in bit 0 |
| privMode | output | 1 | Privileged-mode flag |
| entryDone | output | 1 | One-cycle completion pulse, clears the pending exception |
| fatalErr | output | 1 | Sticky unknown-cause error |
| trapArg0 | output | 64 | Memory-fault address |
| trapArg1 | output | 64 | Memory-fault code |
| trapArg2 | output | 64 | Memory-fault access kind, all ones for fetch |

## Verification
The hardest case to reach from the ports is an entry while already privileged, together with proof that the shadow bank was left alone. Privileged mode is only left by reset, so that case exists only as the second or later entry since reset. The shadow bank is visible only on the `swapWrData` lanes.

The stimulus resets with probability one quarter between random entries. This gives runs of several entries back to back. Each run starts from freshly randomized register contents, so a stray second swap would show up as changed lanes.

Unknown causes are drawn one time in eight. Every accepted entry keeps its request asserted through the `entryDone` cycle, which exercises the hold-off on each trial.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  localparam int CAUSE_W       = 4;
  localparam int HW_SLOT_SHIFT = 7;   // hardware causes spaced 0x80 apart
  localparam int SW_SLOT_SHIFT = 6;   // software-call slots are 64 bytes
  localparam int SW_LOW_BASE   = 32'h1000;
  localparam int SW_HIGH_BASE  = 32'h2000;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_RESET    = 4'd0,
    CAUSE_MCHK     = 4'd1,
    CAUSE_IPI      = 4'd2,
    CAUSE_CLOCK    = 4'd3,
    CAUSE_DEVICE   = 4'd4,
    CAUSE_MEMFAULT = 4'd5,
    CAUSE_UNALIGN  = 4'd6,
    CAUSE_BADOP    = 4'd7,
    CAUSE_ARITH    = 4'd8,
    CAUSE_FPOFF    = 4'd9,
    CAUSE_SWCALL   = 4'd10
  } cause_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic take;       // entry accepted this cycle
    logic doSwap;     // exchange with shadow bank this cycle
    logic takeFault;  // latch memory-fault trap arguments
  } entryStrobe_t;

endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               excValid,
  input  logic [CAUSE_W-1:0] excCause,
  output entryStrobe_t       strobe,
  output logic               privMode,
  output logic               entryDone,
  output logic               fatalErr
);

  logic causeKnown;
  logic idle;
  logic take;
  logic badReq;

  always_comb begin
    causeKnown = (excCause <= CAUSE_SWCALL);
    idle       = !entryDone && !fatalErr;
    take       = excValid && idle && causeKnown;
    badReq     = excValid && idle && !causeKnown;
  end

  always_comb begin
    strobe.take      = take;
    strobe.doSwap    = take && !privMode;
    strobe.takeFault = take && (excCause == CAUSE_MEMFAULT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      privMode  <= 1'b0;
      entryDone <= 1'b0;
      fatalErr  <= 1'b0;
    end else begin
      entryDone <= take;
      if (take)   privMode <= 1'b1;
      if (badReq) fatalErr <= 1'b1;
    end
  end

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |=> !entryDone);

  // R7: an accepted entry always produces the pulse
  assert_done_after_take_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> entryDone);

  // R8: the fatal flag holds until reset
  assert_fatal_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    fatalErr |=> fatalErr);

  // R8: nothing is accepted after a fatal error
  assert_fatal_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    fatalErr |-> !strobe.take);

  // R6: privileged mode is not left without reset
  assert_priv_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    privMode |=> privMode);

endmodule

// File: rtl/trap_entry_dp.sv
module trap_entry_dp
  import trap_entry_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NUM_SWAP = 8,
  parameter int FUNC_W   = 8,
  parameter int FCODE_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  entryStrobe_t             strobe,
  input  logic                     privMode,
  input  logic [CAUSE_W-1:0]       excCause,
  input  logic [FUNC_W-1:0]        callFunc,
  input  logic [XLEN-1:0]          curPc,
  input  logic [XLEN-1:0]          palBase,
  input  logic [XLEN-1:0]          faultAddr,
  input  logic [FCODE_W-1:0]       faultCode,
  input  logic [1:0]               faultKind,
  input  logic [NUM_SWAP*XLEN-1:0] swapRdData,
  output logic [NUM_SWAP*XLEN-1:0] swapWrData,
  output logic [NUM_SWAP-1:0]      swapWrEn,
  output logic [XLEN-1:0]          newPc,
  output logic [XLEN-1:0]          excAddr,
  output logic [XLEN-1:0]          trapArg0,
  output logic [XLEN-1:0]          trapArg1,
  output logic [XLEN-1:0]          trapArg2
);

  // Offset width covers the upper software half plus its slots
  localparam int IDX_W = FUNC_W - 1;
  localparam int OFS_W = IDX_W + SW_SLOT_SHIFT + 2;

  logic [OFS_W-1:0] entryOfs;
  logic [OFS_W-1:0] swHalfBase;

  always_comb begin
    swHalfBase = callFunc[FUNC_W-1] ? OFS_W'(SW_HIGH_BASE) : OFS_W'(SW_LOW_BASE);
    if (excCause == CAUSE_SWCALL)
      entryOfs = swHalfBase + (OFS_W'(callFunc[IDX_W-1:0]) << SW_SLOT_SHIFT);
    else
      entryOfs = OFS_W'(excCause) << HW_SLOT_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newPc    <= '0;
      excAddr  <= '0;
      trapArg0 <= '0;
      trapArg1 <= '0;
      trapArg2 <= '0;
    end else begin
      if (strobe.take) begin
        newPc   <= palBase + XLEN'(entryOfs);
        excAddr <= curPc | XLEN'(privMode);
      end
      if (strobe.takeFault) begin
        trapArg0 <= faultAddr;
        trapArg1 <= XLEN'(faultCode);
        trapArg2 <= faultKind[1] ? {XLEN{1'b1}} : XLEN'(faultKind[0]);
      end
    end
  end

  for (genvar g = 0; g < NUM_SWAP; g++) begin : g_lane
    logic [XLEN-1:0] shadowQ;
    always_ff @(posedge clk) begin
      if (!rstN)              shadowQ <= '0;
      else if (strobe.doSwap) shadowQ <= swapRdData[g*XLEN +: XLEN];
    end
    assign swapWrData[g*XLEN +: XLEN] = shadowQ;
    assign swapWrEn[g]                = strobe.doSwap;
  end

  // R4: bit 0 of the saved address carries the prior mode
  assert_excaddr_mode_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> excAddr[0] == ($past(curPc[0]) | $past(privMode)));

  // R6: a swap is never followed by another swap
  assert_swap_once_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|swapWrEn) |=> !(|swapWrEn));

  // R9: trap arguments only move on a memory-fault entry
  assert_trap_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.takeFault |=> $stable(trapArg0) && $stable(trapArg1) && $stable(trapArg2));

  // R1: the handler address only moves on an accepted entry
  assert_pc_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> $stable(newPc) && $stable(excAddr));

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NUM_SWAP = 8,
  parameter int FUNC_W   = 8,
  parameter int FCODE_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     excValid,
  input  logic [CAUSE_W-1:0]       excCause,
  input  logic [FUNC_W-1:0]        callFunc,
  input  logic [XLEN-1:0]          curPc,
  input  logic [XLEN-1:0]          palBase,
  input  logic [XLEN-1:0]          faultAddr,
  input  logic [FCODE_W-1:0]       faultCode,
  input  logic [1:0]               faultKind,
  input  logic [NUM_SWAP*XLEN-1:0] swapRdData,
  output logic [NUM_SWAP*XLEN-1:0] swapWrData,
  output logic [NUM_SWAP-1:0]      swapWrEn,
  output logic [XLEN-1:0]          newPc,
  output logic [XLEN-1:0]          excAddr,
  output logic                     privMode,
  output logic                     entryDone,
  output logic                     fatalErr,
  output logic [XLEN-1:0]          trapArg0,
  output logic [XLEN-1:0]          trapArg1,
  output logic [XLEN-1:0]          trapArg2
);

  entryStrobe_t strobe;

  trap_entry_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .excValid  (excValid),
    .excCause  (excCause),
    .strobe    (strobe),
    .privMode  (privMode),
    .entryDone (entryDone),
    .fatalErr  (fatalErr)
  );

  trap_entry_dp #(
    .XLEN     (XLEN),
    .NUM_SWAP (NUM_SWAP),
    .FUNC_W   (FUNC_W),
    .FCODE_W  (FCODE_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .privMode   (privMode),
    .excCause   (excCause),
    .callFunc   (callFunc),
    .curPc      (curPc),
    .palBase    (palBase),
    .faultAddr  (faultAddr),
    .faultCode  (faultCode),
    .faultKind  (faultKind),
    .swapRdData (swapRdData),
    .swapWrData (swapWrData),
    .swapWrEn   (swapWrEn),
    .newPc      (newPc),
    .excAddr    (excAddr),
    .trapArg0   (trapArg0),
    .trapArg1   (trapArg1),
    .trapArg2   (trapArg2)
  );

endmodule

// File: tb/test_trap_entry_unit.sv
`timescale 1ns/1ps
module test_trap_entry_unit;

  localparam int XLEN = 64;
  localparam int NSW  = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             excValid = 1'b0;
  logic [3:0]       excCause = '0;
  logic [7:0]       callFunc = '0;
  logic [XLEN-1:0]  curPc = '0, palBase = '0, faultAddr = '0;
  logic [7:0]       faultCode = '0;
  logic [1:0]       faultKind = '0;
  logic [NSW*XLEN-1:0] swapRdData, swapWrData;
  logic [NSW-1:0]   swapWrEn;
  logic [XLEN-1:0]  newPc, excAddr, trapArg0, trapArg1, trapArg2;
  logic             privMode, entryDone, fatalErr;

  always #10 clk = ~clk;  // 50 MHz

  trap_entry_unit i_trap_entry_unit (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excCause(excCause),
    .callFunc(callFunc), .curPc(curPc), .palBase(palBase),
    .faultAddr(faultAddr), .faultCode(faultCode), .faultKind(faultKind),
    .swapRdData(swapRdData), .swapWrData(swapWrData), .swapWrEn(swapWrEn),
    .newPc(newPc), .excAddr(excAddr), .privMode(privMode),
    .entryDone(entryDone), .fatalErr(fatalErr),
    .trapArg0(trapArg0), .trapArg1(trapArg1), .trapArg2(trapArg2)
  );

  // Register-file model for the eight swapped registers
  logic [XLEN-1:0] rf [NSW];
  for (genvar g = 0; g < NSW; g++) begin : g_rf
    assign swapRdData[g*XLEN +: XLEN] = rf[g];
  end
  always @(posedge clk) begin
    for (int i = 0; i < NSW; i++)
      if (swapWrEn[i]) rf[i] <= swapWrData[i*XLEN +: XLEN];
  end

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Expected-state model
  logic [XLEN-1:0] expShadow [NSW];
  logic [XLEN-1:0] expRf [NSW];
  logic [XLEN-1:0] expNewPc, expExc, expA0, expA1, expA2;
  bit expPriv, expFatal;

  task automatic chk(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] expOfs(int c, int f);
    case (c)
      0: return 64'h000;  1: return 64'h080;  2: return 64'h100;
      3: return 64'h180;  4: return 64'h200;  5: return 64'h280;
      6: return 64'h300;  7: return 64'h380;  8: return 64'h400;
      9: return 64'h480;
      default: return (f >= 128) ? 64'(32'h2000 + (f - 128) * 64)
                                 : 64'(32'h1000 + f * 64);
    endcase
  endfunction

  function automatic logic [XLEN-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    excValid = 1'b0;
    for (int i = 0; i < NSW; i++) begin
      rf[i] = rnd64();
      expRf[i] = rf[i];
      expShadow[i] = '0;
    end
    expPriv = 0; expFatal = 0;
    expNewPc = '0; expExc = '0; expA0 = '0; expA1 = '0; expA2 = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R10", "privMode", 64'(privMode), 64'(0));
    chk("R10", "entryDone", 64'(entryDone), 64'(0));
    chk("R10", "fatalErr", 64'(fatalErr), 64'(0));
    chk("R10", "newPc", newPc, '0);
    chk("R10", "excAddr", excAddr, '0);
    chk("R10", "trapArgs", trapArg0 | trapArg1 | trapArg2, '0);
    chk("R10", "shadow", 64'(|swapWrData), 64'(0));
  endtask

  task automatic checkLanes(string req);
    for (int i = 0; i < NSW; i++) begin
      chk(req, $sformatf("rf lane %0d", i), rf[i], expRf[i]);
      chk(req, $sformatf("shadow lane %0d", i), swapWrData[i*XLEN +: XLEN], expShadow[i]);
    end
  endtask

  task automatic runEntry(int c, int f, logic [XLEN-1:0] pc, logic [XLEN-1:0] base,
                          logic [XLEN-1:0] fa, logic [7:0] fc, logic [1:0] fk);
    bit known = (c <= 10);
    string pcReq = (c < 10) ? "R1" : ((f >= 128) ? "R3" : "R2");
    string swReq = expPriv ? "R6" : "R5";
    logic [XLEN-1:0] oldRf [NSW];
    @(negedge clk);
    excCause = 4'(c); callFunc = 8'(f); curPc = pc; palBase = base;
    faultAddr = fa; faultCode = fc; faultKind = fk; excValid = 1'b1;
    #1;
    chk(known ? swReq : "R8", "swapWrEn", 64'(swapWrEn),
        (known && !expPriv) ? 64'hFF : 64'h0);
    for (int i = 0; i < NSW; i++) oldRf[i] = rf[i];
    @(negedge clk);
    if (known) begin
      expNewPc = base + expOfs(c, f);
      expExc   = pc | 64'(expPriv);
      if (!expPriv) begin
        for (int i = 0; i < NSW; i++) begin
          expRf[i] = expShadow[i];
          expShadow[i] = oldRf[i];
        end
      end
      expPriv = 1;
      if (c == 5) begin
        expA0 = fa; expA1 = 64'(fc);
        expA2 = fk[1] ? '1 : 64'(fk[0]);
      end
      chk("R7", "entryDone", 64'(entryDone), 64'(1));
      chk(pcReq, "newPc", newPc, expNewPc);
      chk("R4", "excAddr", excAddr, expExc);
      chk(swReq, "privMode", 64'(privMode), 64'(1));
      checkLanes(swReq);
      chk("R9", "trapArg0", trapArg0, expA0);
      chk("R9", "trapArg1", trapArg1, expA1);
      chk("R9", "trapArg2", trapArg2, expA2);
      chk("R7", "swapWrEn during pulse", 64'(swapWrEn), 64'(0));
      @(negedge clk);  // request still asserted: must be ignored
      chk("R7", "entryDone after pulse", 64'(entryDone), 64'(0));
      chk("R7", "newPc held", newPc, expNewPc);
      chk("R7", "excAddr held", excAddr, expExc);
      excValid = 1'b0;
    end else begin
      expFatal = 1;
      chk("R8", "fatalErr", 64'(fatalErr), 64'(1));
      chk("R8", "entryDone", 64'(entryDone), 64'(0));
      chk("R8", "newPc", newPc, expNewPc);
      chk("R8", "excAddr", excAddr, expExc);
      chk("R8", "privMode", 64'(privMode), 64'(expPriv));
      checkLanes("R8");
      excValid = 1'b0;
      // a valid request after the fault is ignored
      @(negedge clk);
      excCause = 4'd1; excValid = 1'b1;
      @(negedge clk);
      chk("R8", "ignored after fatal", 64'(entryDone), 64'(0));
      chk("R8", "fatal sticky", 64'(fatalErr), 64'(1));
      excValid = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    doReset();
    // Directed corners
    runEntry(0, 0, 64'h1000_0004, 64'h8000_0000, '0, 8'h0, 2'd0);     // R1 lowest, R5 first swap
    runEntry(9, 0, 64'h2000_0008, 64'h8000_0000, '0, 8'h0, 2'd0);     // R1 highest, R6 no swap
    runEntry(10, 8'h00, 64'h30, 64'h4000, '0, 8'h0, 2'd0);            // R2 first slot
    runEntry(10, 8'h7F, 64'h31, 64'h4000, '0, 8'h0, 2'd0);            // R2 last slot
    runEntry(10, 8'h80, 64'h34, 64'h4000, '0, 8'h0, 2'd0);            // R3 first slot
    runEntry(10, 8'hFF, 64'h38, 64'h4000, '0, 8'h0, 2'd0);            // R3 last slot
    runEntry(5, 0, 64'h40, 64'h4000, 64'hDEAD_BEEF_0000_1230, 8'h3, 2'd2); // R9 fetch
    runEntry(5, 0, 64'h44, 64'h4000, 64'h1234, 8'h1, 2'd1);           // R9 write
    runEntry(3, 0, 64'h48, 64'h4000, 64'h9999, 8'h7, 2'd2);           // R9 hold
    runEntry(15, 0, 64'h50, 64'h4000, '0, 8'h0, 2'd0);                // R8
    doReset();
    runEntry(11, 0, 64'h55, 64'h4000, '0, 8'h0, 2'd0);                // R8 from normal mode
    doReset();
    runEntry(10, 8'h85, 64'h61, 64'h10_0000, '0, 8'h0, 2'd0);         // R3 and R5 from normal mode
    // Random trials
    for (int t = 0; t < 400; t++) begin
      int c;
      if (expFatal || ($urandom() % 4 == 0)) doReset();
      c = ($urandom() % 8 == 0) ? 11 + int'($urandom() % 5) : int'($urandom() % 11);
      runEntry(c, int'($urandom() % 256), rnd64(), rnd64(), rnd64(),
               8'($urandom()), 2'($urandom()));
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R7 act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule